// File: doc/BRIEF.md
# Eight-to-One Word Serializer

This block turns a stream of parallel words into a serial bit stream. It takes one word per word period through a valid/ready handshake and shifts its bits out least significant first. It also drives a framing clock at word rate. That clock marks word boundaries for the receiver, and the upstream source can use it as a trigger. Words follow each other with no gap. The serial side has no back-pressure: a serializer must emit one bit per bit slot.

A rate-select input picks one of two modes. In full rate, one bit leaves per clock cycle. In half rate, each bit is held for two cycles by an internal phase toggle. The ratio of serial bits to framing-clock periods is the word width in both modes. A high-active sync input clears every flop at once, without waiting for a clock edge. When it drops, the block restarts on clock edges, so a partial word is never emitted. A hold input freezes all state at a clock edge, and releasing it resumes at a clock edge. The rate select may only change while sync is high.

Back-pressure rules on the input side:
- `in_ready` is high for a single cycle per word period, the slot cycle.
- A word is taken on the rising edge where `in_valid` and `in_ready` are both high.
- A source that is not ready keeps its word and waits for the next slot.
- A slot that passes with `in_valid` low still uses its word period, and an all-zero word is sent in its place.

Top module: `word_serializer`

## Requirements
- R1: While `sync_rst` is high, `ser_out`, `frame_clk` and `in_ready` are 0. Raising `sync_rst` clears them at once, even in the middle of a word.
- R2: Each word is sent bit 0 first through bit 7 last, one bit per bit slot. The next word follows directly with no idle slot between words.
- R3: In full-rate mode (`rate_sel` = 0), the first slot is the 2nd rising edge after `sync_rst` is seen low. Bit 0 of a word appears after the 7th rising edge following the edge that took it. Each bit then lasts one cycle.
- R4: In half-rate mode (`rate_sel` = 1), the first slot is the 3rd rising edge after release. Bit 0 appears after the 14th rising edge following the word's slot. Each bit lasts two cycles.
- R5: `in_ready` is high for exactly one cycle per word period: every 8 cycles in full rate and every 16 in half rate. A word is taken only on an edge where `in_valid` and `in_ready` are both high.
- R6: If `in_valid` is low during a slot, an all-zero word fills that word period. The source's pending word is taken at the next slot.
- R7: A rising edge with `hold` high changes no state. While `hold` is high, `ser_out` and `frame_clk` keep their values and `in_ready` is 0. After `hold` drops, the stream continues exactly where it stopped.
- R8: After release, `frame_clk` is high while the bit counter is in the first half of the word period (slots 0 to 3) and low for the second half. `in_ready` is only ever high while `frame_clk` is high.
- R9: After a release that follows a reset taken in the middle of a word, `ser_out` stays 0 until bit 0 of the first new word. No bit of the interrupted word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| sync_rst | input | 1 | Asynchronous clear when high; the restart is taken on clock edges |
| rate_sel | input | 1 | 0 = one bit per cycle, 1 = one bit per two cycles; change only while `sync_rst` is high |
| hold | input | 1 | High freezes all state at the next rising edge |
| in_data | input | WIDTH | Parallel word, bit 0 sent first |
| in_valid | input | 1 | Source offers `in_data` |
| in_ready | output | 1 | Slot cycle: the word is taken at the coming edge if valid |
| ser_out | output | 1 | Serial bit stream |
| frame_clk | output | 1 | Word-rate framing clock, high in the first half of each word period |

## Verification
The first corner case is the restart after release. The bench checks that the first slot comes on the 2nd or 3rd edge and that bit 0 arrives exactly 7 or 14 edges later. An off-by-one counter or divider shows up as a shifted or smeared bit. The hold test freezes the stream in the middle of a word in both modes. A design that let the phase or counter run on would drop or repeat a bit after resume, or raise `in_ready` while held. The bench also lets a slot pass with `in_valid` low, to catch a design that stalls or sends stale data. Finally, it asserts `sync_rst` in the middle of a word, to catch a late clear or leftover bits of the old word after the restart.

// File: rtl/wser_pkg.sv
`timescale 1ns/1ps
package wser_pkg;
  // Serial rate selection: one bit per clock or one bit per two clocks.
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;
endpackage

// File: rtl/wser_ctrl.sv
`timescale 1ns/1ps
// Sequencing: run flag after release, half-rate phase, bit-slot counter,
// framing clock and input slot strobe.
module wser_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic            clk,
  input  logic            sync_rst,
  input  wser_pkg::rate_e rate,
  input  logic            hold,
  output logic            tick,
  output logic            first_slot,
  output logic            last_slot,
  output logic            frame_clk,
  output logic            in_ready
);
  localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int HALF = WIDTH / 2;

  logic          run_q;
  logic          phase_q;
  logic [CW-1:0] cnt_q;

  // A bit slot advances only when running, not held, and (half rate) on phase 1.
  assign tick       = run_q & ~hold & ((rate == wser_pkg::RATE_HALF) ? phase_q : 1'b1);
  assign first_slot = (cnt_q == '0);
  assign last_slot  = (cnt_q == CW'(WIDTH - 1));
  assign frame_clk  = run_q & (cnt_q < CW'(HALF));
  assign in_ready   = tick & first_slot;

  always_ff @(posedge clk or posedge sync_rst) begin
    if (sync_rst) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q && !hold) begin
        phase_q <= ~phase_q;
        if (tick) cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (sync_rst)
    hold |=> ($stable(cnt_q) && $stable(phase_q)));

  assert_half_gap_R4: assert property (@(posedge clk) disable iff (sync_rst)
    (rate == wser_pkg::RATE_HALF && tick) |=> !tick);

  assert_ready_in_frame_R8: assert property (@(posedge clk) disable iff (sync_rst)
    in_ready |-> frame_clk);
endmodule

// File: rtl/wser_capture.sv
`timescale 1ns/1ps
// Word capture register: loads the offered word at the slot, or zero on underrun.
module wser_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             sync_rst,
  input  logic             take,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic [WIDTH-1:0] word_q
);
  always_ff @(posedge clk or posedge sync_rst) begin
    if (sync_rst)  word_q <= '0;
    else if (take) word_q <= in_valid ? in_data : '0;
  end
endmodule

// File: rtl/wser_shift.sv
`timescale 1ns/1ps
// Output shift register: reloaded from the capture register on the last slot,
// shifted toward bit 0 on every other slot.
module wser_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             sync_rst,
  input  logic             tick,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  output logic             ser_out
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk or posedge sync_rst) begin
    if (sync_rst)  sh_q <= '0;
    else if (load) sh_q <= word;
    else if (tick) sh_q <= {1'b0, sh_q[WIDTH-1:1]};
  end

  assign ser_out = sh_q[0];

  assert_quiet_between_ticks_R2: assert property (@(posedge clk) disable iff (sync_rst)
    !tick |=> $stable(ser_out));
endmodule

// File: rtl/word_serializer.sv
`timescale 1ns/1ps
module word_serializer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             sync_rst,
  input  logic             rate_sel,
  input  logic             hold,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             ser_out,
  output logic             frame_clk
);
  wser_pkg::rate_e  rate_mode;
  logic             tick;
  logic             first_slot;
  logic             last_slot;
  logic [WIDTH-1:0] word_q;

  assign rate_mode = wser_pkg::rate_e'(rate_sel);

  wser_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .sync_rst   (sync_rst),
    .rate       (rate_mode),
    .hold       (hold),
    .tick       (tick),
    .first_slot (first_slot),
    .last_slot  (last_slot),
    .frame_clk  (frame_clk),
    .in_ready   (in_ready)
  );

  wser_capture #(.WIDTH(WIDTH)) u_capture (
    .clk      (clk),
    .sync_rst (sync_rst),
    .take     (tick & first_slot),
    .in_valid (in_valid),
    .in_data  (in_data),
    .word_q   (word_q)
  );

  wser_shift #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .sync_rst (sync_rst),
    .tick     (tick),
    .load     (tick & last_slot),
    .word     (word_q),
    .ser_out  (ser_out)
  );
endmodule

// File: tb/tb_word_serializer.sv
`timescale 1ns/1ps
module tb_word_serializer;
  localparam int W  = 8;
  localparam int NV = 4;
  // {rate, word A, word B}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'h80},
    {1'b1, 8'hF0, 8'h5A},
    {1'b1, 8'h81, 8'h7E}
  };

  logic clk = 1'b0;
  logic sync_rst = 1'b1;
  logic rate_sel = 1'b0;
  logic hold = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, ser_out, frame_clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m, s, f, ncap, pidx;
  int cap_m [64];
  logic [W-1:0] cap_w [64];
  logic [W-1:0] va, vb;
  string sec_tag = "";

  always #10 clk = ~clk;

  word_serializer #(.WIDTH(W)) dut (
    .clk       (clk),
    .sync_rst  (sync_rst),
    .rate_sel  (rate_sel),
    .hold      (hold),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ser_out   (ser_out),
    .frame_clk (frame_clk)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] word_of(input int p);
    return ((p % 2) != 0 ? vb : va) ^ W'(17 * (p / 2));
  endfunction

  // Index of the word whose bit is on the line after active edge mm, or -1.
  function automatic int win_idx(input int mm);
    for (int k = 0; k < ncap; k++) begin
      int d = mm - cap_m[k];
      if (d >= 7 * s && d < 15 * s) return k;
    end
    return -1;
  endfunction

  function automatic logic exp_ser(input int mm);
    int k = win_idx(mm);
    if (k < 0) return 1'b0;
    return cap_w[k][(mm - cap_m[k] - 7 * s) / s];
  endfunction

  function automatic logic exp_ready(input int mm);
    int n = mm + 1;
    return (n >= f) && (((n - f) % (8 * s)) == 0);
  endfunction

  function automatic logic exp_frame(input int mm);
    int t = (mm >= f) ? ((mm - f) / s + 1) : 0;
    return (mm >= 1) && ((t % W) < W / 2);
  endfunction

  task automatic start_run(input logic r);
    @(negedge clk);
    sync_rst = 1'b1; rate_sel = r; hold = 1'b0; in_valid = 1'b0;
    @(negedge clk); #1;
    chk("R1", ser_out, 1'b0);
    chk("R1", frame_clk, 1'b0);
    chk("R1", in_ready, 1'b0);
    s = r ? 2 : 1; f = r ? 3 : 2; m = 0; ncap = 0; pidx = 0;
    sync_rst = 1'b0;
  endtask

  task automatic cyc(input logic h, input logic v);
    logic r_exp;
    string rtag, stag;
    int k;
    hold = h; in_valid = v; in_data = word_of(pidx);
    #1;
    r_exp = !h && exp_ready(m);
    rtag = (sec_tag != "") ? sec_tag : "R5";
    chk(rtag, in_ready, r_exp);
    @(posedge clk);
    if (r_exp) begin
      cap_m[ncap] = m + 1;
      cap_w[ncap] = v ? in_data : '0;
      ncap++;
      if (v) pidx++;
    end
    if (!h || m == 0) m++;
    @(negedge clk); #1;
    k = win_idx(m);
    if (sec_tag != "") stag = sec_tag;
    else if (k == 0)   stag = (s == 2) ? "R4" : "R3";
    else               stag = "R2";
    chk(stag, ser_out, exp_ser(m));
    chk((sec_tag != "") ? sec_tag : "R8", frame_clk, exp_frame(m));
  endtask

  initial begin
    // R1: reset state from time zero
    repeat (2) @(negedge clk); #1;
    chk("R1", ser_out, 1'b0);
    chk("R1", frame_clk, 1'b0);
    chk("R1", in_ready, 1'b0);

    // Vector table: both rates, several bit patterns, back-to-back words
    for (int i = 0; i < NV; i++) begin
      vb = VEC[i][W-1:0];
      va = VEC[i][2*W-1:W];
      start_run(VEC[i][2*W]);
      for (int c = 0; c < (VEC[i][2*W] ? 80 : 40); c++) cyc(1'b0, 1'b1);
    end

    // R7: hold in the middle of a word, full rate
    va = 8'hC3; vb = 8'h96;
    start_run(1'b0);
    repeat (12) cyc(1'b0, 1'b1);
    sec_tag = "R7";
    repeat (5) cyc(1'b1, 1'b1);
    sec_tag = "";
    repeat (24) cyc(1'b0, 1'b1);

    // R7: hold across a slot in half rate
    start_run(1'b1);
    repeat (18) cyc(1'b0, 1'b1);
    sec_tag = "R7";
    repeat (3) cyc(1'b1, 1'b1);
    sec_tag = "";
    repeat (40) cyc(1'b0, 1'b1);

    // R6: slot passes with no valid word
    va = 8'h6B; vb = 8'hD4;
    start_run(1'b0);
    repeat (8) cyc(1'b0, 1'b1);
    sec_tag = "R6";
    repeat (3) cyc(1'b0, 1'b0);
    repeat (16) cyc(1'b0, 1'b1);
    sec_tag = "";
    repeat (12) cyc(1'b0, 1'b1);

    // R1 and R9: reset in the middle of a word, then a clean restart
    va = 8'h5E; vb = 8'hA1;
    start_run(1'b0);
    repeat (13) cyc(1'b0, 1'b1);
    #3 sync_rst = 1'b1;
    #1;
    chk("R1", ser_out, 1'b0);
    chk("R1", frame_clk, 1'b0);
    chk("R1", in_ready, 1'b0);
    va = 8'h3F; vb = 8'hC2;
    start_run(1'b0);
    sec_tag = "R9";
    repeat (24) cyc(1'b0, 1'b1);
    sec_tag = "";

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule